// File: doc/BRIEF.md
# Luma Subcarrier Trap and Horizontal Peaking Filter

This block sits after a luma/chroma separator. It processes 8-bit luma sampled at four times the colour subcarrier rate, in two stages. The first stage is a mild notch that lowers residual subcarrier energy in the luma path to about three quarters of its amplitude. The second stage is a 3-tap horizontal peaking filter. It lifts high horizontal frequencies to make up for the droop that a sample-and-hold output converter adds. Each stage has its own enable. In pass-through separation mode both stages are bypassed, whatever their enables.

Samples enter with a valid strobe, and the filter taps advance only on valid samples. A stage that is disabled is replaced by a delay of the same length as the filter it bypasses. The total latency is therefore the same for every combination of enables and modes.

Top module: `luma_trap_peak`

## Requirements
- R1: While rst_ni is low, and after it is released until the first valid sample has passed through, y_o is 0 and valid_o is 0.
- R2: valid_o equals valid_i delayed by exactly two clock cycles. y_o changes only on the edge that raises valid_o for a cycle, and holds its value in every other cycle.
- R3: Number the valid samples x[j], with x[j]=0 for j<0. With the trap active, the trap value for sample j is t[j] = (x[j-2] + x[j+2] + 14*x[j] + 8) >> 4. This gives unity gain at DC and at half the sample rate.
- R4: For a tone at one quarter of the sample rate (the period-4 pattern 128,192,128,64), the trap scales the deviation about the mean by 0.75 (about -2.5 dB). The peaks become 176 and 80.
- R5: With the peaking stage active, and inputs a, b, c being the trap values t[n-2], t[n-3], t[n-4], the output is (10*b - a - c + 4) >> 3. It has unity gain at DC.
- R6: The peaking result is clamped to the range 0..255. Negative sums give 0 and sums above 255 give 255.
- R7: A disabled stage passes its centre tap, t[j]=x[j] or y=b. The output for the sample accepted with index n is always the filtered value centred on x[n-3], for every enable setting.
- R8: With mode_i = 2'b11 (pass-through), both stages are bypassed regardless of trap_en_i and peak_en_i, and y_o carries x[n-3].
- R9: Mode values 2'b00 (adaptive), 2'b10 (bandpass only) and 2'b01 all let the enables take effect.
- R10: Cycles with valid_i low do not advance any tap. A stream with gaps gives the same output sequence as the same stream without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input sample strobe |
| y_i | input | DW (8) | Separated luma sample |
| trap_en_i | input | 1 | 1 enables the subcarrier trap |
| peak_en_i | input | 1 | 1 enables horizontal peaking |
| mode_i | input | 2 | Separation mode: 00 adaptive, 10 bandpass, 11 pass-through, 01 treated as filtering |
| y_o | output | DW (8) | Filtered luma |
| valid_o | output | 1 | Output sample strobe |

## Verification
The assertions assume that mode and enables are quasi-static. Each stage applies the settings present on the edge where it fires, and a check on stage output ties that output to the settings of the same cycle. The stimulus changes mode and enables only after two idle cycles, so that no sample is split across two configurations in the pipeline. The reference model relies on this as well: it records one configuration per accepted sample and uses it for both stages.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [1:0] {
    SEP_ADAPT = 2'b00,
    SEP_RSVD  = 2'b01,
    SEP_BAND  = 2'b10,
    SEP_THRU  = 2'b11
  } sep_mode_e;

  localparam int TRAP_TAPS = 5;
  localparam int PEAK_TAPS = 3;
endpackage

// File: rtl/lt_tap_line.sv
module lt_tap_line #(
  parameter int DW   = 8,
  parameter int NTAP = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      adv_i,
  input  logic [DW-1:0]             d_i,
  output logic [NTAP-1:0][DW-1:0]   win_o
);
  logic [NTAP-2:0][DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (adv_i) begin
      q[0] <= d_i;
      for (int i = 1; i < NTAP-1; i++) q[i] <= q[i-1];
    end
  end

  assign win_o[0] = d_i;
  for (genvar g = 0; g < NTAP-1; g++) begin : g_win
    assign win_o[g+1] = q[g];
  end
endmodule

// File: rtl/lt_trap_stage.sv
module lt_trap_stage
  import lt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          en_i,
  input  logic [TRAP_TAPS-1:0][DW-1:0]  win_i,
  output logic [DW-1:0]                 y_o,
  output logic                          valid_o
);
  // k = 1/4 of a highpass scaled by 1/4 -> total shift 4
  localparam int KSH  = 2;
  localparam int HSH  = 2;
  localparam int SH   = KSH + HSH;
  localparam int CTR  = (1 << SH) - 2;
  localparam int SW   = DW + SH + 1;
  localparam int CTAP = TRAP_TAPS / 2;

  logic [SW-1:0] acc;
  logic [DW-1:0] filt;

  always_comb begin
    acc  = SW'(win_i[0]) + SW'(win_i[TRAP_TAPS-1])
         + SW'(win_i[CTAP]) * SW'(CTR) + SW'(1 << (SH-1));
    filt = acc[SH +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= en_i ? filt : win_i[CTAP];
    end
  end
endmodule

// File: rtl/lt_peak_stage.sv
module lt_peak_stage
  import lt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          en_i,
  input  logic [PEAK_TAPS-1:0][DW-1:0]  win_i,
  output logic [DW-1:0]                 y_o,
  output logic                          valid_o
);
  localparam int SH   = 3;
  localparam int CTR  = (1 << SH) + 2;
  localparam int PW   = DW + SH + 2;
  localparam int CTAP = PEAK_TAPS / 2;

  logic [PW-1:0] acc;
  logic          neg, over;
  logic [DW-1:0] filt;

  always_comb begin
    // two's complement in PW bits; top bit is the sign
    acc  = PW'(win_i[CTAP]) * PW'(CTR) - PW'(win_i[0])
         - PW'(win_i[PEAK_TAPS-1]) + PW'(1 << (SH-1));
    neg  = acc[PW-1];
    over = |acc[PW-2:SH+DW];
    if (neg)       filt = '0;
    else if (over) filt = '1;
    else           filt = acc[SH +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= en_i ? filt : win_i[CTAP];
    end
  end
endmodule

// File: rtl/luma_trap_peak.sv
module luma_trap_peak
  import lt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] y_i,
  input  logic          trap_en_i,
  input  logic          peak_en_i,
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] y_o,
  output logic          valid_o
);
  logic                          thru;
  logic                          trap_act, peak_act;
  logic [TRAP_TAPS-1:0][DW-1:0]  trap_win;
  logic [DW-1:0]                 trap_y;
  logic                          trap_vld;
  logic [PEAK_TAPS-1:0][DW-1:0]  peak_win;

  assign thru     = (mode_i == SEP_THRU);
  assign trap_act = trap_en_i & ~thru;
  assign peak_act = peak_en_i & ~thru;

  lt_tap_line #(.DW(DW), .NTAP(TRAP_TAPS)) i_trap_taps (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(valid_i), .d_i(y_i), .win_o(trap_win)
  );

  lt_trap_stage #(.DW(DW)) i_trap (
    .clk_i  (clk_i),   .rst_ni (rst_ni),  .valid_i(valid_i), .en_i(trap_act),
    .win_i  (trap_win), .y_o   (trap_y),  .valid_o(trap_vld)
  );

  lt_tap_line #(.DW(DW), .NTAP(PEAK_TAPS)) i_peak_taps (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(trap_vld), .d_i(trap_y), .win_o(peak_win)
  );

  lt_peak_stage #(.DW(DW)) i_peak (
    .clk_i  (clk_i),   .rst_ni (rst_ni),  .valid_i(trap_vld), .en_i(peak_act),
    .win_i  (peak_win), .y_o   (y_o),     .valid_o(valid_o)
  );
endmodule

// File: rtl/luma_trap_peak_chk.sv
module luma_trap_peak_chk
  import lt_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          valid_i,
  input logic [1:0]                    mode_i,
  input logic                          valid_o,
  input logic [DW-1:0]                 y_o,
  input logic [TRAP_TAPS-1:0][DW-1:0]  trap_win,
  input logic [DW-1:0]                 trap_y,
  input logic                          trap_vld,
  input logic [PEAK_TAPS-1:0][DW-1:0]  peak_win
);
  localparam int TC = TRAP_TAPS / 2;
  localparam int PC = PEAK_TAPS / 2;

  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R2
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && !valid_o) |-> $stable(y_o));

  // R3
  trap_dc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && trap_win[0] == trap_win[TC] && trap_win[TC] == trap_win[TRAP_TAPS-1])
    |=> (trap_y == $past(trap_win[TC])));

  // R5
  peak_dc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_vld && peak_win[0] == peak_win[PC] && peak_win[PC] == peak_win[PEAK_TAPS-1])
    |=> (y_o == $past(peak_win[PC])));

  // R8
  thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == SEP_THRU) |=> (trap_y == $past(trap_win[TC])));
endmodule

bind luma_trap_peak luma_trap_peak_chk #(.DW(DW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .valid_o (valid_o),
  .y_o     (y_o),
  .trap_win(trap_win),
  .trap_y  (trap_y),
  .trap_vld(trap_vld),
  .peak_win(peak_win)
);

// File: tb/test_luma_trap_peak.sv
module test_luma_trap_peak;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       vin;
  logic [7:0] din;
  logic       ten, pen;
  logic [1:0] mode;
  logic [7:0] yo;
  logic       vo;

  always #2 clk = ~clk;

  luma_trap_peak #(.DW(8)) i_luma_trap_peak (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .y_i(din),
    .trap_en_i(ten), .peak_en_i(pen), .mode_i(mode),
    .y_o(yo), .valid_o(vo)
  );

  int    vectors = 0;
  int    errors  = 0;
  string tag     = "R1";
  bit    done    = 0;

  int xq[$];
  bit ta[$];
  bit pa[$];
  int exp_y = 0;
  bit exp_v = 0;
  bit vd1   = 0;
  int pend  = 0;

  function automatic int xv(int j);
    if (j < 0) return 0;
    return xq[j];
  endfunction

  function automatic int tv(int k);
    int c;
    if (k < -2) return 0;
    c = xv(k);
    if (!ta[k+2]) return c;
    return (xv(k-2) + xv(k+2) + 14*c + 8) / 16;
  endfunction

  function automatic int yv(int n);
    int a, b, c, s;
    b = tv(n-3);
    if (!pa[n]) return b;
    a = tv(n-2);
    c = tv(n-4);
    s = 10*b - a - c + 4;
    if (s < 0) return 0;
    s = s / 8;
    if (s > 255) return 255;
    return s;
  endfunction

  // behavioural reference, advanced at each edge from the driven inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_y = 0; exp_v = 0; vd1 = 0; pend = 0;
      xq.delete(); ta.delete(); pa.delete();
    end else begin
      if (vd1) exp_y = pend;
      exp_v = vd1;
      vd1   = vin;
      if (vin) begin
        xq.push_back(int'(din));
        ta.push_back(ten && mode != 2'b11);
        pa.push_back(pen && mode != 2'b11);
        pend = yv(xq.size() - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (!rst_n) begin
        if (vo !== 1'b0 || yo !== 8'd0) begin
          errors++;
          $display("FAIL R1: valid_o=%0b y_o=%0d expected valid_o=0 y_o=0", vo, yo);
        end
      end else if (vo !== exp_v || yo !== exp_y[7:0]) begin
        errors++;
        $display("FAIL %s (latency R2): valid_o=%0b y_o=%0d expected valid_o=%0b y_o=%0d",
                 tag, vo, yo, exp_v, exp_y);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  task automatic drive(input bit v, input int d);
    @(negedge clk);
    vin = v;
    din = d[7:0];
  endtask

  task automatic cfg(input bit t, input bit p, input logic [1:0] m, input string tg);
    drive(0, 0);
    drive(0, 0);
    ten  = t;
    pen  = p;
    mode = m;
    tag  = tg;
  endtask

  task automatic rand_run(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) drive(0, 0);
      drive(1, int'($urandom % 256));
    end
  endtask

  initial begin
    vin = 0; din = 0; ten = 0; pen = 0; mode = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R7 R10: both stages off, gapped random stream
    cfg(0, 0, 2'b00, "R7 R10");
    rand_run(200, 1);

    // R4: quarter-rate tone through trap only
    cfg(1, 0, 2'b00, "R4");
    for (int i = 0; i < 64; i++) begin
      drive(1, 128); drive(1, 192); drive(1, 128); drive(1, 64);
    end

    // R3: trap only, bandpass mode, random with gaps
    cfg(1, 0, 2'b10, "R3 R10");
    rand_run(300, 1);

    // R5: peaking only
    cfg(0, 1, 2'b10, "R5");
    rand_run(300, 0);

    // R6: saturation at both ends
    cfg(0, 1, 2'b00, "R6");
    for (int i = 0; i < 40; i++) begin
      drive(1, 0);   drive(1, 0);   drive(1, 255); drive(1, 0);   drive(1, 0);
      drive(1, 255); drive(1, 255); drive(1, 255); drive(1, 0);   drive(1, 255);
    end

    // R7: impulse, latency equal across enable sets
    cfg(1, 1, 2'b00, "R7");
    for (int i = 0; i < 8; i++) begin drive(1, 255); rand_run(0, 0); repeat (7) drive(1, 0); end
    cfg(1, 0, 2'b00, "R7");
    for (int i = 0; i < 8; i++) begin drive(1, 255); repeat (7) drive(1, 0); end

    // R9: reserved and adaptive modes both filter
    cfg(1, 1, 2'b01, "R9");
    rand_run(200, 0);
    cfg(1, 1, 2'b00, "R9 R10");
    rand_run(200, 1);

    // R8: pass-through overrides enables
    cfg(1, 1, 2'b11, "R8");
    rand_run(200, 1);
    cfg(0, 1, 2'b11, "R8");
    rand_run(50, 0);

    repeat (6) drive(0, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion before timeout");
      done = 1;
      summary();
      $finish;
    end
  end
endmodule